// File: doc/BRIEF.md
# Command Descriptor Length Sequencer

This block sits on the target side of a parallel peripheral bus during the command phase. After a start pulse it requests command descriptor bytes one at a time through a request/valid handshake. The top three bits of the first byte name a command group, and that group decides how many bytes the sequencer requests in total. Every accepted byte goes into a small buffer at the position given by its arrival order. When the final byte is in, the request drops, a one-cycle completion pulse is raised, and a group-recognised status flag shows whether the group code was one the block knows.

Group 2 commands have a configurable length. When extended descriptor support is on, they are 10-byte commands and count as recognised. When it is off, they are 6-byte commands and the status flag stays clear. Either of two configuration inputs turns extended support on.

The controller has four states. IDLE waits for `start`. FIRST requests and decodes the opening byte. REST requests the remaining bytes. FINISH lasts one cycle and carries the completion pulse. The transitions are:
- IDLE goes to FIRST on `start`.
- FIRST goes to REST when a byte is accepted.
- REST goes to FINISH when the last expected byte is accepted.
- FINISH goes to IDLE on the next cycle.
- Any state goes to FIRST on `start`.

Top module: `cdb_len_seq`

## Requirements
- R1: While reset is asserted, and right after it, `byte_req`, `done` and `grp_valid` are 0, `byte_cnt` is 0 and `cdb_bytes` is all zero.
- R2: A `start` pulse clears `cdb_bytes`, `byte_cnt` and `grp_valid`. `byte_req` is 1 from the next cycle onward.
- R3: The group code is bits 7:5 of the first accepted byte. Group 0 gives 6 bytes, group 1 gives 10 bytes and group 5 gives 12 bytes. Each of these sets `grp_valid` from the cycle after the first byte is accepted.
- R4: A group 2 first byte gives 10 bytes and sets `grp_valid` when `cfg_ext_en` is 1, when `cfg_alt_en` is 1, or when both are 1.
- R5: A group 2 first byte gives 6 bytes and leaves `grp_valid` at 0 when both configuration inputs are 0.
- R6: Groups 3, 4, 6 and 7 give 6 bytes and leave `grp_valid` at 0.
- R7: A byte is accepted in a cycle where `byte_req` and `byte_vld` are both 1. The byte accepted as the i-th (counting from 0) lands in `cdb_bytes[8*i+7:8*i]`, and `byte_cnt` goes up by one for each accepted byte.
- R8: In the cycle after the last expected byte is accepted, `byte_req` is 0 and `done` is 1. `done` is 1 for exactly one cycle.
- R9: A `byte_vld` while `byte_req` is 0 changes neither `cdb_bytes` nor `byte_cnt`.
- R10: A `start` in the middle of a sequence abandons it and begins a new one from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new command sequence |
| cfg_ext_en | input | 1 | Extended descriptor enable |
| cfg_alt_en | input | 1 | Second enable for extended descriptors |
| byte_vld | input | 1 | Incoming byte valid |
| byte_in | input | 8 | Incoming command byte |
| byte_req | output | 1 | Request for the next byte |
| cdb_bytes | output | 96 | Buffered bytes, byte i at bits 8i+7:8i |
| byte_cnt | output | 4 | Number of bytes received |
| done | output | 1 | One-cycle completion pulse |
| grp_valid | output | 1 | Group code recognised |

## Verification
A wrong latched length shows up as `byte_req` staying high past the expected final byte, or dropping before it, together with a `done` pulse in the wrong cycle. This appears no later than the cycle after the shorter of the two lengths is reached. A wrong state decode or a wrong counter value appears at `byte_cnt`, `byte_req` or `done` in the very next cycle. A misdirected buffer write appears in `cdb_bytes` in the cycle after the faulty acceptance. Because the reference model is compared on every clock, each of these faults is reported in the first cycle where it becomes visible.

// File: rtl/cdb_seq_pkg.sv
package cdb_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_REST,
        ST_FINISH
    } seq_state_t;

    localparam int GRP_W = 3;
endpackage

// File: rtl/cdb_grp_decode.sv
module cdb_grp_decode #(
    parameter int CNT_W     = 4,
    parameter int LEN_SHORT = 6,
    parameter int LEN_MID   = 10,
    parameter int LEN_LONG  = 12
) (
    input  logic [cdb_seq_pkg::GRP_W-1:0] grp,
    input  logic                          ext_on,
    output logic [CNT_W-1:0]              len,
    output logic                          known
);
    always_comb begin
        len   = CNT_W'(LEN_SHORT);
        known = 1'b0;
        unique case (grp)
            3'd0: begin len = CNT_W'(LEN_SHORT); known = 1'b1; end
            3'd1: begin len = CNT_W'(LEN_MID);   known = 1'b1; end
            3'd2: begin
                len   = ext_on ? CNT_W'(LEN_MID) : CNT_W'(LEN_SHORT);
                known = ext_on;
            end
            3'd5: begin len = CNT_W'(LEN_LONG);  known = 1'b1; end
            default: begin len = CNT_W'(LEN_SHORT); known = 1'b0; end
        endcase
    end
endmodule

// File: rtl/cdb_byte_store.sv
module cdb_byte_store #(
    parameter int DEPTH = 12,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         din,
    output logic [DEPTH*8-1:0] flat
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else if (clr)
                slot_q <= '0;
            else if (we && idx == IDX_W'(i))
                slot_q <= din;
        end
        assign flat[8*i +: 8] = slot_q;
    end

    // R2: a clear empties every slot on the following cycle
    assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flat == '0));
endmodule

// File: rtl/cdb_len_seq.sv
module cdb_len_seq #(
    parameter int MAX_BYTES = 12,
    parameter int LEN_SHORT = 6,
    parameter int LEN_MID   = 10,
    parameter int LEN_LONG  = 12,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   cfg_ext_en,
    input  logic                   cfg_alt_en,
    input  logic                   byte_vld,
    input  logic [7:0]             byte_in,
    output logic                   byte_req,
    output logic [MAX_BYTES*8-1:0] cdb_bytes,
    output logic [CNT_W-1:0]       byte_cnt,
    output logic                   done,
    output logic                   grp_valid
);
    import cdb_seq_pkg::*;

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, len_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] dec_len;
    logic             dec_known;
    logic             valid_q;
    logic             accept;
    logic             last_byte;

    assign cnt_inc   = cnt_q + CNT_W'(1);
    assign accept    = byte_req && byte_vld && !start;
    assign last_byte = (state_q == ST_REST) && (cnt_inc == len_q);

    cdb_grp_decode #(
        .CNT_W(CNT_W), .LEN_SHORT(LEN_SHORT),
        .LEN_MID(LEN_MID), .LEN_LONG(LEN_LONG)
    ) u_decode (
        .grp    (byte_in[7:5]),
        .ext_on (cfg_ext_en | cfg_alt_en),
        .len    (dec_len),
        .known  (dec_known)
    );

    cdb_byte_store #(.DEPTH(MAX_BYTES), .IDX_W(CNT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .we    (accept),
        .idx   (cnt_q),
        .din   (byte_in),
        .flat  (cdb_bytes)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_FIRST:  if (accept) state_d = ST_REST;
            ST_REST:   if (accept && last_byte) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
        if (start) state_d = ST_FIRST;
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                cnt_q   <= '0;
                len_q   <= '0;
                valid_q <= 1'b0;
            end else if (accept) begin
                cnt_q <= cnt_inc;
                if (state_q == ST_FIRST) begin
                    len_q   <= dec_len;
                    valid_q <= dec_known;
                end
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        byte_req = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FIRST:  byte_req = 1'b1;
            ST_REST:   byte_req = 1'b1;
            ST_FINISH: done     = 1'b1;
        endcase
    end

    assign byte_cnt  = cnt_q;
    assign grp_valid = valid_q;

    // R8: completion lasts a single cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion only follows an accepted byte, and request is down
    assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(byte_req && byte_vld) && !byte_req));

    // R7: count never runs past the buffer
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(MAX_BYTES));

    // R9: bytes offered without a request leave state untouched
    assert_ignore_unrequested_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_req && !start) |=> ($stable(byte_cnt) && $stable(cdb_bytes)));

    // R2: start clears status and count, then requests
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (byte_cnt == '0 && !grp_valid && byte_req));
endmodule

// File: tb/cdb_len_seq_test.sv
module cdb_len_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cfg_ext_en = 1'b0;
    logic          cfg_alt_en = 1'b0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_in = 8'h00;
    logic          byte_req;
    logic [NB*8-1:0] cdb_bytes;
    logic [3:0]    byte_cnt;
    logic          done;
    logic          grp_valid;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    // reference model state
    bit       m_act, m_done, m_valid;
    int       m_cnt, m_len;
    bit [7:0] m_buf [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    cdb_len_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_ext_en(cfg_ext_en), .cfg_alt_en(cfg_alt_en),
        .byte_vld(byte_vld), .byte_in(byte_in),
        .byte_req(byte_req), .cdb_bytes(cdb_bytes), .byte_cnt(byte_cnt),
        .done(done), .grp_valid(grp_valid)
    );

    function automatic int exp_len(input bit [7:0] b, input bit ext);
        case (b[7:5])
            3'd1: return 10;
            3'd2: return ext ? 10 : 6;
            3'd5: return 12;
            default: return 6;
        endcase
    endfunction

    function automatic bit exp_known(input bit [7:0] b, input bit ext);
        return (b[7:5] == 3'd0) || (b[7:5] == 3'd1) || (b[7:5] == 3'd5) ||
               (b[7:5] == 3'd2 && ext);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0; m_done = 0; m_valid = 0; m_cnt = 0; m_len = 0;
            for (int i = 0; i < NB; i++) m_buf[i] = 8'h00;
        end else begin
            m_done = 0;
            if (start) begin
                m_act = 1; m_cnt = 0; m_len = 0; m_valid = 0;
                for (int i = 0; i < NB; i++) m_buf[i] = 8'h00;
            end else if (m_act && byte_vld) begin
                m_buf[m_cnt] = byte_in;
                if (m_cnt == 0) begin
                    m_len   = exp_len(byte_in, cfg_ext_en | cfg_alt_en);
                    m_valid = exp_known(byte_in, cfg_ext_en | cfg_alt_en);
                end
                m_cnt++;
                if (m_cnt == m_len) begin
                    m_act = 0; m_done = 1;
                end
            end
        end
    end

    task automatic cmp(input string what, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        logic [NB*8-1:0] eb;
        for (int i = 0; i < NB; i++) eb[8*i +: 8] = m_buf[i];
        cmp("byte_req", 128'(byte_req), 128'(m_act));
        cmp("done", 128'(done), 128'(m_done));
        cmp("byte_cnt", 128'(byte_cnt), 128'(m_cnt));
        cmp("grp_valid", 128'(grp_valid), 128'(m_valid));
        cmp("cdb_bytes", 128'(cdb_bytes), 128'(eb));
    end

    task automatic push(input logic [7:0] b);
        byte_in = b; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic run_cmd(input logic [7:0] first, input int nsend, input bit gaps);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < nsend; i++) begin
            push(i == 0 ? first : 8'(i * 29 + 7));
            if (gaps && i[0]) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        tag = "R3"; run_cmd(8'h03, 6, 0);
        run_cmd(8'h28, 10, 1);
        run_cmd(8'hA8, 12, 0);
        tag = "R4"; cfg_ext_en = 1; run_cmd(8'h48, 10, 0);
        cfg_ext_en = 0; cfg_alt_en = 1; run_cmd(8'h5A, 10, 1);
        cfg_ext_en = 1; run_cmd(8'h40, 10, 0);
        tag = "R5"; cfg_ext_en = 0; cfg_alt_en = 0; run_cmd(8'h48, 6, 0);
        checks++;
        if (grp_valid !== 1'b0 || byte_cnt !== 4'd6) begin
            errors++;
            $display("FAIL R5 final: got valid=%0b cnt=%0d expected valid=0 cnt=6", grp_valid, byte_cnt);
        end
        tag = "R6"; run_cmd(8'h60, 6, 0);
        run_cmd(8'h9F, 6, 1);
        run_cmd(8'hC0, 6, 0);
        run_cmd(8'hE5, 6, 0);
        tag = "R7"; run_cmd(8'h11, 6, 1);
        tag = "R9";
        push(8'hEE); push(8'h77);
        run_cmd(8'h02, 9, 0);
        tag = "R10"; run_cmd(8'hA1, 3, 0);
        run_cmd(8'h21, 10, 0);
        tag = "R2"; run_cmd(8'h05, 0, 0);
        tag = "R8"; run_cmd(8'hB3, 12, 1);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule